// File: doc/BRIEF.md
# Single-Bit Test Branch Resolver

This block resolves a conditional branch whose condition is one bit of a 64-bit register. The decode stage presents the fetch address of the branch, a signed 16-bit word displacement, a 6-bit index that selects the bit to test, and a polarity select. When the polarity select is 1 the branch is taken if the selected bit is 1. When it is 0 the branch is taken if the selected bit is 0. The decode stage also presents the register value and a flag that marks a branch sitting inside another branch's delay or forbidden slot.

One cycle after a valid strobe, the block reports four results: whether the branch is taken, the computed destination, whether the next instruction must be handled as a 32-bit delay slot, and whether a reserved-instruction exception must be raised instead. A branch found inside a slot raises the exception. It neither branches nor arms a slot. Redirecting fetch and executing the delay-slot instruction are left to the surrounding pipeline.

Top module: `bit_branch_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, outValid, taken, armSlot and riExc are 0 and target is 0.
- R2: outValid is 1 in the cycle after a cycle with inValid=1, and 0 in the cycle after a cycle with inValid=0.
- R3: For a valid branch with inSlot=0, bitIdx=n selects regVal[n], where bit 0 is the least significant bit. With branchOnSet=1, taken is 1 exactly when that bit is 1. With branchOnSet=0, taken is 1 exactly when that bit is 0.
- R4: After every valid strobe, target equals pcIn + 4 + (offsetIn sign-extended to 64 bits, times 4), taken modulo 2^64. The exception and the condition do not change this value.
- R5: For a valid branch with inSlot=1, riExc is 1 and both taken and armSlot are 0, whatever the value of the tested bit.
- R6: For a valid branch with inSlot=0, riExc is 0 and armSlot is 1, whether or not the branch is taken.
- R7: In the cycle after a cycle with inValid=0, taken, armSlot and riExc are 0, and target keeps its previous value.
- R8: Every bit index from 0 to 63 is decoded, under both polarity values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | A branch is presented this cycle |
| pcIn | input | 64 | Address of the branch instruction |
| offsetIn | input | 16 | Signed displacement, counted in 4-byte words |
| bitIdx | input | 6 | Index of the register bit to test |
| branchOnSet | input | 1 | 1: branch when the bit is 1; 0: branch when the bit is 0 |
| regVal | input | 64 | Register value to test |
| inSlot | input | 1 | The branch sits inside another branch's slot |
| outValid | output | 1 | The results below belong to the previous cycle's strobe |
| taken | output | 1 | The branch is taken |
| target | output | 64 | Branch destination address |
| armSlot | output | 1 | Treat the next instruction as a 32-bit delay slot |
| riExc | output | 1 | Raise a reserved-instruction exception |

## Verification
Every result (outValid, taken, target, armSlot and riExc) is registered once, so each one is due at the first rising edge after the cycle in which its inputs were presented. The bench changes inputs on the falling edge. It waits for the next rising edge and reads the outputs one nanosecond later, before any new input can arrive. An idle cycle is checked the same way, to confirm that the flags clear while the destination holds. The sweep covers all 64 indices, both polarities, both bit values and the slot flag. It also covers the extreme displacements and address wrap at both ends of the address space.

// File: rtl/bbu_pkg.sv
package bbu_pkg;

  // Strobes the control sends to the datapath and to its own result flops
  typedef struct packed {
    logic loadTarget;  // capture the destination address
    logic capture;     // a branch is being resolved
    logic excNow;      // the branch faults because it sits in a slot
    logic takeNow;     // the branch condition holds and no fault
  } ctlStrobes_t;

endpackage

// File: rtl/bbu_dpath.sv
module bbu_dpath
  import bbu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int OFFW  = 16,
  parameter int INSTB = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobes_t              strobes,
  input  logic [XLEN-1:0]          pcIn,
  input  logic [OFFW-1:0]          offsetIn,
  input  logic [$clog2(XLEN)-1:0]  bitIdx,
  input  logic                     branchOnSet,
  input  logic [XLEN-1:0]          regVal,
  output logic                     condBit,
  output logic [XLEN-1:0]          target
);
  localparam int SHIFT = $clog2(INSTB);
  localparam int EXTW  = XLEN - OFFW;

  logic [XLEN-1:0] offExt;
  logic [XLEN-1:0] offScaled;
  logic [XLEN-1:0] seqPc;
  logic [XLEN-1:0] targetNext;
  logic [XLEN-1:0] bitMask;
  logic            selBit;

  // A one-hot mask is built for the chosen index, then reduced with the register
  for (genvar i = 0; i < XLEN; i++) begin : g_mask
    assign bitMask[i] = (bitIdx == i[$clog2(XLEN)-1:0]);
  end

  always_comb begin
    selBit  = |(bitMask & regVal);
    condBit = branchOnSet ? selBit : ~selBit;
  end

  always_comb begin
    offExt     = {{EXTW{offsetIn[OFFW-1]}}, offsetIn};
    offScaled  = offExt << SHIFT;
    seqPc      = pcIn + XLEN'(INSTB);
    targetNext = seqPc + offScaled;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      target <= '0;
    end else if (strobes.loadTarget) begin
      target <= targetNext;
    end
  end

  // R7
  target_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadTarget |=> $stable(target));

endmodule

// File: rtl/bbu_ctrl.sv
module bbu_ctrl
  import bbu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inSlot,
  input  logic        condBit,
  output ctlStrobes_t strobes,
  output logic        outValid,
  output logic        taken,
  output logic        armSlot,
  output logic        riExc
);

  always_comb begin
    strobes.capture    = inValid;
    strobes.loadTarget = inValid;
    strobes.excNow     = inValid & inSlot;
    strobes.takeNow    = inValid & ~inSlot & condBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      taken    <= 1'b0;
      armSlot  <= 1'b0;
      riExc    <= 1'b0;
    end else begin
      outValid <= strobes.capture;
      taken    <= strobes.takeNow;
      armSlot  <= strobes.capture & ~strobes.excNow;
      riExc    <= strobes.excNow;
    end
  end

  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (outValid == $past(inValid)));

  // R3
  cond_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inSlot) |=> (taken == $past(condBit)));

  // R5
  exc_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    riExc |-> (!taken && !armSlot));

  // R6
  arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !riExc) |-> armSlot);

  // R7
  idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !(taken || armSlot || riExc));

endmodule

// File: rtl/bit_branch_unit.sv
module bit_branch_unit
  import bbu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int OFFW  = 16,
  parameter int INSTB = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [XLEN-1:0]          pcIn,
  input  logic [OFFW-1:0]          offsetIn,
  input  logic [$clog2(XLEN)-1:0]  bitIdx,
  input  logic                     branchOnSet,
  input  logic [XLEN-1:0]          regVal,
  input  logic                     inSlot,
  output logic                     outValid,
  output logic                     taken,
  output logic [XLEN-1:0]          target,
  output logic                     armSlot,
  output logic                     riExc
);
  ctlStrobes_t strobes;
  logic        condBit;

  bbu_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inSlot   (inSlot),
    .condBit  (condBit),
    .strobes  (strobes),
    .outValid (outValid),
    .taken    (taken),
    .armSlot  (armSlot),
    .riExc    (riExc)
  );

  bbu_dpath #(.XLEN(XLEN), .OFFW(OFFW), .INSTB(INSTB)) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .pcIn        (pcIn),
    .offsetIn    (offsetIn),
    .bitIdx      (bitIdx),
    .branchOnSet (branchOnSet),
    .regVal      (regVal),
    .condBit     (condBit),
    .target      (target)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (!outValid && !taken && !armSlot && !riExc && target == '0));

endmodule

// File: tb/bit_branch_unit_test.sv
module bit_branch_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] pcIn = '0;
  logic [15:0] offsetIn = '0;
  logic [5:0]  bitIdx = '0;
  logic        branchOnSet = 1'b0;
  logic [63:0] regVal = '0;
  logic        inSlot = 1'b0;
  logic        outValid, taken, armSlot, riExc;
  logic [63:0] target;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  bit_branch_unit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .pcIn(pcIn), .offsetIn(offsetIn),
    .bitIdx(bitIdx), .branchOnSet(branchOnSet), .regVal(regVal), .inSlot(inSlot),
    .outValid(outValid), .taken(taken), .target(target), .armSlot(armSlot), .riExc(riExc)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] expTarget(input logic [63:0] pc, input logic [15:0] off);
    logic signed [63:0] s;
    s = 64'(signed'(off));
    return pc + 64'd4 + 64'(s * 4);
  endfunction

  task automatic branch(input logic [63:0] pc, input logic [15:0] off, input int idx,
                        input bit pol, input logic [63:0] val, input bit slot);
    bit bitv, expTaken;
    @(negedge clk);
    inValid = 1'b1; pcIn = pc; offsetIn = off; bitIdx = 6'(idx);
    branchOnSet = pol; regVal = val; inSlot = slot;
    @(posedge clk); #1;
    bitv = val[idx];
    expTaken = !slot && (pol ? bitv : !bitv);
    chk("R2 outValid", 64'(outValid), 64'd1);
    chk(slot ? "R5 taken" : "R3 R8 taken", 64'(taken), 64'(expTaken));
    chk("R4 target", target, expTarget(pc, off));
    chk(slot ? "R5 armSlot" : "R6 armSlot", 64'(armSlot), 64'(!slot));
    chk(slot ? "R5 riExc" : "R6 riExc", 64'(riExc), 64'(slot));
  endtask

  task automatic idle(input logic [63:0] holdT);
    @(negedge clk);
    inValid = 1'b0; regVal = ~regVal; pcIn = pcIn + 64'd100; inSlot = ~inSlot;
    @(posedge clk); #1;
    chk("R2 outValid idle", 64'(outValid), 64'd0);
    chk("R7 flags idle", {61'd0, taken, armSlot, riExc}, 64'd0);
    chk("R7 target hold", target, holdT);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 flags in reset", {60'd0, outValid, taken, armSlot, riExc}, 64'd0);
    chk("R1 target in reset", target, 64'd0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1 flags after reset", {60'd0, outValid, taken, armSlot, riExc}, 64'd0);
    chk("R1 target after reset", target, 64'd0);

    // R3 R8: every index, both polarities, bit set and clear
    for (int i = 0; i < 64; i++) begin
      for (int p = 0; p < 2; p++) begin
        branch(64'h1000 + 64'(i * 8), 16'(i), i, p[0], 64'd1 << i, 1'b0);
        branch(64'h2000, 16'hFFFF - 16'(i), i, p[0], ~(64'd1 << i), 1'b0);
        branch(64'h3000, 16'(i), i, p[0], 64'hA5A5_5A5A_F00F_0FF0, 1'b0);
      end
    end

    // R5: slot faults regardless of the bit, target still computed
    for (int i = 0; i < 64; i += 7) begin
      branch(64'h4000, 16'h0010, i, 1'b1, '1, 1'b1);
      branch(64'h4000, 16'h8000, i, 1'b0, '0, 1'b1);
    end

    // R4 boundary displacements and wrap
    branch(64'h0000_0000_0001_0000, 16'h7FFF, 0, 1'b1, 64'd1, 1'b0);
    branch(64'h0000_0000_0004_0000, 16'h8000, 0, 1'b1, 64'd0, 1'b0);
    branch(64'hFFFF_FFFF_FFFF_FFFC, 16'h0000, 63, 1'b1, 64'h8000_0000_0000_0000, 1'b0);
    branch(64'h0000_0000_0000_0000, 16'hFFFE, 5, 1'b0, 64'd0, 1'b0);
    branch(64'hFFFF_FFFF_FFFF_FFF0, 16'h0010, 1, 1'b0, 64'd2, 1'b0);

    // R7 idle cycles after a branch
    branch(64'h5000, 16'h0040, 9, 1'b1, 64'd1 << 9, 1'b0);
    idle(expTarget(64'h5000, 16'h0040));
    idle(expTarget(64'h5000, 16'h0040));
    branch(64'h6000, 16'h0001, 9, 1'b1, 64'd0, 1'b1);
    idle(expTarget(64'h6000, 16'h0001));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule